// File: doc/BRIEF.md
# Cyclic egress gate scheduler

This block drives the transmission gates of one egress port according to a repeating time schedule. Software fills a shadow list of entries, each entry holding an 8-bit gate vector and a duration counted in 200 ns slots. It then commits the list together with a start time and a cycle length. Once the free-running nanosecond clock reaches the start time, the block walks the active list from entry 0. It presents the current gate vector to the queue logic, and bit n high means traffic class n may transmit. When the cycle length has elapsed it wraps back to entry 0.

All gate changes fall on a 200 ns grid that is anchored at the start time. A commit is checked before it is accepted. A list that would make two gate events land in the same slot is refused, and so is a list that runs past the cycle end. A refused commit raises an error flag and the running schedule stays untouched. A commit that is accepted while a schedule runs waits in a pending bank and takes over only at the next cycle boundary, so a running cycle is never cut short. A one-cycle strobe and an entry index mark every change of entry. The enable input gates only what reaches the ports: while it is low, all gates read open and no strobe appears, but the schedule keeps its phase.

The time input must advance by less than 200 ns per clock.

Top module: `tas_gate_sched`

## Requirements
- R1: While a schedule runs and enable_i is high, gate_o equals the mask of the entry that covers the current slot. Bit n of gate_o set means class n may transmit.
- R2: After reset, before any valid commit and while time_ns_i is below the committed start time, gate_o is 8'hFF and evt_o is 0.
- R3: Slot k covers time_ns_i in [base + 200k, base + 200(k+1)). The output for a slot appears on the first clock edge at which time_ns_i lies inside that slot.
- R4: Entry i lasts its programmed number of slots and the entries follow one another in index order. When the cycle length exceeds the sum of the entries, the last entry holds until the cycle ends. Slot base + cycle*j always starts entry 0.
- R5: evt_o is high for one clock at each entry start: the first start, every later entry, and every cycle start. evt_idx_o then gives the new index, and the index changes only with evt_o.
- R6: With enable_i low, gate_o is 8'hFF and evt_o is 0, while the schedule phase keeps advancing. Raising enable_i again shows the entry that the unbroken schedule would show.
- R7: cfg_err_o is high on the clock after a commit that would put two gate events in one slot (an entry of zero slots) or that has a length of 0. It is also high after a commit whose entries sum to more than cfg_cycle_i. Such a commit leaves the active and pending schedules unchanged.
- R8: An accepted commit clears cfg_err_o on the next clock.
- R9: An accepted commit made while a schedule runs takes effect at the next cycle boundary. The new list starts at entry 0 in that slot and uses its own cycle length, and the start time is not reapplied. Shadow writes alone change nothing at the ports.
- R10: An accepted commit made before the start time is reached replaces the active list and the start time at once. Gates stay open until the new start time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_ns_i | input | TIME_W | Free-running time in nanoseconds |
| enable_i | input | 1 | Gating enable; low forces all gates open |
| cfg_wr_i | input | 1 | Write one shadow entry |
| cfg_idx_i | input | IDX_W | Shadow entry index |
| cfg_mask_i | input | 8 | Gate vector of the entry |
| cfg_slots_i | input | DUR_W | Entry duration in 200 ns slots |
| cfg_commit_i | input | 1 | Validate and commit the shadow list |
| cfg_len_i | input | IDX_W+1 | Number of entries in the committed list |
| cfg_cycle_i | input | CYC_W | Cycle length in slots |
| cfg_base_i | input | TIME_W | Start time in ns (applied only when no schedule runs) |
| gate_o | output | 8 | Gate-open vector, one bit per traffic class |
| evt_o | output | 1 | One-cycle strobe at each entry start |
| evt_idx_o | output | IDX_W | Index of the current entry |
| cfg_err_o | output | 1 | Last commit was refused |

## Verification
A slot counter or deadline that drifts by one shows up as a gate vector changing one slot early or late. It is visible within 200 ns of the first wrong boundary and grows every cycle after that, so every sampled clock is compared with a model driven by time alone. An entry pointer that is not reset at a cycle wrap, or a pending bank that is swapped at the wrong time, shows up as a wrong mask and a missing or extra strobe at the first cycle boundary after the commit. A validation fault shows on the clock after the commit, as a wrong level on cfg_err_o or as gates that leave the old list.

// File: rtl/tas_gsch_pkg.sv
package tas_gsch_pkg;
  localparam int NUM_TC  = 8;
  localparam int DUR_W   = 16;
  localparam int SLOT_NS = 200;

  typedef logic [NUM_TC-1:0] gate_t;

  typedef struct packed {
    gate_t            mask;
    logic [DUR_W-1:0] slots;
  } ent_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} st_e;
endpackage

// File: rtl/tas_gsch_slot_timer.sv
module tas_gsch_slot_timer #(
  parameter int TIME_W  = 64,
  parameter int SLOT_NS = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] base_i,
  input  logic              wait_i,
  input  logic              run_i,
  output logic              start_o,
  output logic              tick_o
);
  localparam logic [TIME_W-1:0] SLOT = TIME_W'(SLOT_NS);

  logic [TIME_W-1:0] dl_q;

  assign start_o = wait_i && (time_i >= base_i);
  assign tick_o  = run_i && (time_i >= dl_q);

  // deadline tracks the start of the next slot on the base-anchored grid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dl_q <= '0;
    else if (start_o) dl_q <= base_i + SLOT;
    else if (tick_o)  dl_q <= dl_q + SLOT;
  end
endmodule

// File: rtl/tas_gsch_store.sv
module tas_gsch_store
  import tas_gsch_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int TIME_W = 64,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int LEN_W = IDX_W + 1,
  localparam int CYC_W = DUR_W + IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  ent_t              wr_ent_i,
  input  logic              commit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [TIME_W-1:0] base_i,
  input  logic              running_i,
  input  logic              swap_i,
  output ent_t              act_o [N_ENT],
  output logic [LEN_W-1:0]  act_len_o,
  output logic [CYC_W-1:0]  act_cyc_o,
  output logic [TIME_W-1:0] act_base_o,
  output ent_t              head_o,
  output logic              have_o,
  output logic              ok_o,
  output logic              err_o
);
  ent_t              shd_q [N_ENT];
  ent_t              pnd_q [N_ENT];
  ent_t              act_q [N_ENT];
  logic [LEN_W-1:0]  pnd_len_q, act_len_q;
  logic [CYC_W-1:0]  pnd_cyc_q, act_cyc_q;
  logic [TIME_W-1:0] act_base_q;
  logic              pend_q, have_q, err_q;

  logic [N_ENT-1:0]  in_use, is_zero;
  logic [CYC_W-1:0]  sum;

  for (genvar g = 0; g < N_ENT; g++) begin : g_chk
    assign in_use[g]  = LEN_W'(g) < len_i;
    assign is_zero[g] = in_use[g] && (shd_q[g].slots == '0);
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_ENT; i++)
      if (in_use[i]) sum = sum + CYC_W'(shd_q[i].slots);
  end

  // zero-slot entry = two events in one slot; sum beyond cycle = overrun
  assign ok_o = (len_i != '0) && (len_i <= LEN_W'(N_ENT)) &&
                (is_zero == '0) && (sum <= cyc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) begin
        shd_q[i] <= '0;
        pnd_q[i] <= '0;
        act_q[i] <= '0;
      end
      pnd_len_q  <= '0;
      act_len_q  <= '0;
      pnd_cyc_q  <= '0;
      act_cyc_q  <= '0;
      act_base_q <= '0;
      pend_q     <= 1'b0;
      have_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (wr_i) shd_q[wr_idx_i] <= wr_ent_i;
      if (swap_i && pend_q) begin
        act_q     <= pnd_q;
        act_len_q <= pnd_len_q;
        act_cyc_q <= pnd_cyc_q;
        pend_q    <= 1'b0;
      end
      if (commit_i) begin
        err_q <= !ok_o;
        if (ok_o) begin
          if (!running_i) begin
            act_q      <= shd_q;
            act_len_q  <= len_i;
            act_cyc_q  <= cyc_i;
            act_base_q <= base_i;
            have_q     <= 1'b1;
            pend_q     <= 1'b0;
          end else begin
            pnd_q     <= shd_q;
            pnd_len_q <= len_i;
            pnd_cyc_q <= cyc_i;
            pend_q    <= 1'b1;
          end
        end
      end
    end
  end

  assign act_o      = act_q;
  assign act_len_o  = act_len_q;
  assign act_cyc_o  = act_cyc_q;
  assign act_base_o = act_base_q;
  assign head_o     = pend_q ? pnd_q[0] : act_q[0];
  assign have_o     = have_q;
  assign err_o      = err_q;
endmodule

// File: rtl/tas_gsch_walker.sv
module tas_gsch_walker
  import tas_gsch_pkg::*;
#(
  parameter int N_ENT  = 8,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int LEN_W = IDX_W + 1,
  localparam int CYC_W = DUR_W + IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             have_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  ent_t             act_i [N_ENT],
  input  logic [LEN_W-1:0] len_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  ent_t             head_i,
  output logic             wait_o,
  output logic             run_o,
  output logic             swap_o,
  output gate_t            mask_o,
  output logic             evt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CYC_W-1:0] pos_o
);
  st_e              st_q;
  logic [IDX_W-1:0] idx_q, nidx;
  logic [DUR_W-1:0] left_q;
  logic [CYC_W-1:0] pos_q;
  gate_t            mask_q;
  logic             evt_q, last, more;

  assign nidx   = idx_q + IDX_W'(1);
  assign last   = (pos_q == cyc_i - CYC_W'(1));
  assign more   = ({1'b0, idx_q} + LEN_W'(1)) < len_i;
  assign swap_o = (st_q == ST_RUN) && tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      left_q <= '0;
      pos_q  <= '0;
      mask_q <= '1;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (have_i) st_q <= ST_WAIT;
        ST_WAIT: if (start_i) begin
          st_q   <= ST_RUN;
          idx_q  <= '0;
          left_q <= act_i[0].slots;
          pos_q  <= '0;
          mask_q <= act_i[0].mask;
          evt_q  <= 1'b1;
        end
        ST_RUN: if (tick_i) begin
          if (last) begin
            // cycle wrap: head comes from the pending list if one waits
            pos_q  <= '0;
            idx_q  <= '0;
            left_q <= head_i.slots;
            mask_q <= head_i.mask;
            evt_q  <= 1'b1;
          end else begin
            pos_q <= pos_q + CYC_W'(1);
            if (left_q == DUR_W'(1) && more) begin
              idx_q  <= nidx;
              left_q <= act_i[nidx].slots;
              mask_q <= act_i[nidx].mask;
              evt_q  <= 1'b1;
            end else if (left_q != '0) begin
              left_q <= left_q - DUR_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wait_o = (st_q == ST_WAIT);
  assign run_o  = (st_q == ST_RUN);
  assign mask_o = mask_q;
  assign evt_o  = evt_q;
  assign idx_o  = idx_q;
  assign pos_o  = pos_q;
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import tas_gsch_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int TIME_W = 64,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int LEN_W = IDX_W + 1,
  localparam int CYC_W = DUR_W + IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_ns_i,
  input  logic              enable_i,
  input  logic              cfg_wr_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [NUM_TC-1:0] cfg_mask_i,
  input  logic [DUR_W-1:0]  cfg_slots_i,
  input  logic              cfg_commit_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [CYC_W-1:0]  cfg_cycle_i,
  input  logic [TIME_W-1:0] cfg_base_i,
  output logic [NUM_TC-1:0] gate_o,
  output logic              evt_o,
  output logic [IDX_W-1:0]  evt_idx_o,
  output logic              cfg_err_o
);
  ent_t              act_w [N_ENT];
  ent_t              head_w;
  logic [LEN_W-1:0]  act_len_w;
  logic [CYC_W-1:0]  act_cyc_w, pos_w;
  logic [TIME_W-1:0] act_base_w;
  logic              have_w, cfg_ok, wait_w, run_w, swap_w;
  logic              start_w, tick_w, walk_evt;
  gate_t             mask_w;
  logic [IDX_W-1:0]  idx_w;

  tas_gsch_store #(.N_ENT(N_ENT), .TIME_W(TIME_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr_i),
    .wr_idx_i  (cfg_idx_i),
    .wr_ent_i  ('{mask: cfg_mask_i, slots: cfg_slots_i}),
    .commit_i  (cfg_commit_i),
    .len_i     (cfg_len_i),
    .cyc_i     (cfg_cycle_i),
    .base_i    (cfg_base_i),
    .running_i (run_w),
    .swap_i    (swap_w),
    .act_o     (act_w),
    .act_len_o (act_len_w),
    .act_cyc_o (act_cyc_w),
    .act_base_o(act_base_w),
    .head_o    (head_w),
    .have_o    (have_w),
    .ok_o      (cfg_ok),
    .err_o     (cfg_err_o)
  );

  tas_gsch_slot_timer #(.TIME_W(TIME_W), .SLOT_NS(SLOT_NS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .time_i (time_ns_i),
    .base_i (act_base_w),
    .wait_i (wait_w),
    .run_i  (run_w),
    .start_o(start_w),
    .tick_o (tick_w)
  );

  tas_gsch_walker #(.N_ENT(N_ENT)) u_walker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .have_i (have_w),
    .start_i(start_w),
    .tick_i (tick_w),
    .act_i  (act_w),
    .len_i  (act_len_w),
    .cyc_i  (act_cyc_w),
    .head_i (head_w),
    .wait_o (wait_w),
    .run_o  (run_w),
    .swap_o (swap_w),
    .mask_o (mask_w),
    .evt_o  (walk_evt),
    .idx_o  (idx_w),
    .pos_o  (pos_w)
  );

  assign gate_o    = (run_w && enable_i) ? mask_w : '1;
  assign evt_o     = walk_evt && enable_i;
  assign evt_idx_o = idx_w;
endmodule

// File: rtl/tas_gate_sched_chk.sv
module tas_gate_sched_chk #(
  parameter int N_ENT  = 8,
  parameter int CYC_W  = 20,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int LEN_W = IDX_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             cfg_commit_i,
  input logic             cfg_ok,
  input logic             cfg_err_o,
  input logic [7:0]       gate_o,
  input logic             evt_o,
  input logic             walk_evt,
  input logic             run_w,
  input logic [IDX_W-1:0] idx_w,
  input logic [LEN_W-1:0] act_len_w,
  input logic [CYC_W-1:0] pos_w
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;

  p_closed_needs_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o != 8'hFF) |-> (run_w && enable_i));

  p_evt_when_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> run_w);

  p_idx_in_list_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> ({1'b0, idx_w} < act_len_w));

  p_wrap_head_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_evt && pos_w == '0) |-> (idx_w == '0));

  p_idx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !walk_evt) |-> $stable(idx_w));

  p_reject_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_commit_i && !cfg_ok) |=> cfg_err_o);

  p_accept_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_commit_i && cfg_ok) |=> !cfg_err_o);
endmodule

bind tas_gate_sched tas_gate_sched_chk #(.N_ENT(N_ENT), .CYC_W(CYC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .cfg_commit_i(cfg_commit_i),
  .cfg_ok      (cfg_ok),
  .cfg_err_o   (cfg_err_o),
  .gate_o      (gate_o),
  .evt_o       (evt_o),
  .walk_evt    (walk_evt),
  .run_w       (run_w),
  .idx_w       (idx_w),
  .act_len_w   (act_len_w),
  .pos_w       (pos_w)
);

// File: tb/tas_gate_sched_bench.sv
`timescale 1ns/1ps
module tas_gate_sched_bench;
  localparam int N_ENT = 8;
  localparam int IDX_W = 3;
  localparam int LEN_W = 4;
  localparam int CYC_W = 20;

  typedef struct packed {
    logic       sel;
    logic [2:0] idx;
    logic [7:0] mask;
    logic [15:0] slots;
  } row_t;

  // schedule A (sel 0) and schedule B (sel 1)
  localparam row_t ROWS [5] = '{
    '{1'b0, 3'd0, 8'h80, 16'd2},
    '{1'b0, 3'd1, 8'h7F, 16'd3},
    '{1'b0, 3'd2, 8'h0A, 16'd1},
    '{1'b1, 3'd0, 8'h01, 16'd1},
    '{1'b1, 3'd1, 8'h3C, 16'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  logic [63:0] tnow = '0;
  logic cfg_wr = 0, cfg_commit = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [7:0] cfg_mask = '0;
  logic [15:0] cfg_slots = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [CYC_W-1:0] cfg_cyc = '0;
  logic [63:0] cfg_base = '0;
  logic [7:0] gate;
  logic evt, err;
  logic [IDX_W-1:0] eidx;

  always #4 clk = ~clk;

  tas_gate_sched #(.N_ENT(N_ENT), .TIME_W(64)) u_tas_gate_sched (
    .clk_i(clk), .rst_ni(rst_n), .time_ns_i(tnow), .enable_i(en),
    .cfg_wr_i(cfg_wr), .cfg_idx_i(cfg_idx), .cfg_mask_i(cfg_mask),
    .cfg_slots_i(cfg_slots), .cfg_commit_i(cfg_commit), .cfg_len_i(cfg_len),
    .cfg_cycle_i(cfg_cyc), .cfg_base_i(cfg_base),
    .gate_o(gate), .evt_o(evt), .evt_idx_o(eidx), .cfg_err_o(err));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int a_mask [4], a_sl [4], b_mask [4], b_sl [4];
  int a_len = 3, a_cyc = 8, a_sum = 6, b_len = 2, b_cyc = 5;
  longint base = 64'd12000;
  longint swap_slot = 64'h7FFF_FFFF_FFFF;
  longint prev_slot = -1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at t=%0d: actual %0h expected %0h", req, tnow, act, exp);
    end
  endtask

  function automatic void lookup(input bit useb, input longint pos, output int idx, output bit st);
    longint acc = 0;
    int n = useb ? b_len : a_len;
    idx = n - 1; st = 0;
    for (int i = 0; i < n; i++) begin
      longint d = useb ? b_sl[i] : a_sl[i];
      if (pos < acc + d) begin idx = i; st = (pos == acc); break; end
      acc += d;
    end
  endfunction

  task automatic step();
    longint slot, pos;
    int idx;
    bit st, useb, running, exp_e;
    logic [7:0] exp_g;
    string tag;
    @(negedge clk);
    running = rst_n && (longint'(tnow) >= base);
    exp_e = 0; exp_g = 8'hFF; idx = 0; pos = 0; useb = 0;
    if (running) begin
      slot = (longint'(tnow) - base) / 200;
      useb = slot >= swap_slot;
      pos  = useb ? (slot - swap_slot) % b_cyc : slot % a_cyc;
      lookup(useb, pos, idx, st);
      if (en) exp_g = useb ? b_mask[idx][7:0] : a_mask[idx][7:0];
      exp_e = en && (slot != prev_slot) && st;
      prev_slot = slot;
    end else prev_slot = -1;
    if (!running) tag = (tnow >= 8000 && tnow < 12000) ? "R10" : "R2";
    else if (!en) tag = "R6";
    else if (useb) tag = "R9";
    else if (pos >= a_sum) tag = "R4";
    else if ((longint'(tnow) - base) % 200 == 0) tag = "R3";
    else tag = "R1";
    check(gate == exp_g, tag, gate, exp_g);
    check(evt == exp_e, en ? "R5" : "R6", evt, exp_e);
    if (exp_e) check(eidx == IDX_W'(idx), "R5", eidx, idx);
    tnow = tnow + 8;
  endtask

  task automatic write_rows(input bit sel);
    foreach (ROWS[i]) if (ROWS[i].sel == sel) begin
      cfg_wr = 1; cfg_idx = ROWS[i].idx; cfg_mask = ROWS[i].mask; cfg_slots = ROWS[i].slots;
      step();
      cfg_wr = 0;
    end
  endtask

  task automatic commit(input int len, input int cyc, input longint b);
    cfg_commit = 1; cfg_len = LEN_W'(len); cfg_cyc = CYC_W'(cyc); cfg_base = b;
    step();
    cfg_commit = 0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    foreach (ROWS[i]) begin
      if (ROWS[i].sel) begin b_mask[ROWS[i].idx] = ROWS[i].mask; b_sl[ROWS[i].idx] = ROWS[i].slots; end
      else             begin a_mask[ROWS[i].idx] = ROWS[i].mask; a_sl[ROWS[i].idx] = ROWS[i].slots; end
    end
    repeat (3) step();
    check(gate == 8'hFF && !evt && !err, "R2 reset", {gate, evt, err}, {8'hFF, 2'b00});
    rst_n = 1;
    step();
    write_rows(0);
    commit(3, 8, 8000);
    check(err == 0, "R8", err, 0);
    while (tnow < 2000) step();
    commit(3, 8, 12000);          // re-base before start: R10
    check(err == 0, "R10", err, 0);
    while (tnow < 16400) step();

    // refused commits while running: R7
    cfg_wr = 1; cfg_idx = 1; cfg_mask = 8'h7F; cfg_slots = 0; step(); cfg_wr = 0;
    commit(3, 8, 0);
    check(err == 1, "R7 zero-slot", err, 1);
    cfg_wr = 1; cfg_slots = 3; step(); cfg_wr = 0;
    commit(3, 5, 0);
    check(err == 1, "R7 overrun", err, 1);
    commit(0, 8, 0);
    check(err == 1, "R7 empty", err, 1);
    repeat (250) step();

    en = 0;                        // R6
    repeat (60) step();
    en = 1;
    repeat (300) step();

    write_rows(1);                 // shadow only, gates must still follow A
    while (!(((longint'(tnow) + 8 - base) / 200) % a_cyc == 3 &&
             (longint'(tnow) + 8 - base) % 200 == 40)) step();
    swap_slot = (((longint'(tnow) + 8 - base) / 200) / a_cyc + 1) * a_cyc;
    commit(2, 5, 0);
    check(err == 0, "R8 clear", err, 0);
    while ((longint'(tnow) - base) / 200 < swap_slot + 3 * b_cyc) step();

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule